// File: doc/BRIEF.md
# Packed Default Attribute Register Loader

This block is a register-write front end that fills a table of sixteen four-component vectors. Each component is a 24-bit float value, and the block treats it as raw bits. A host first writes a slot number into an index register. It then writes three 32-bit data words. The block collects the three words and splits the 96 bits into four 24-bit components. It stores the vector in the slot that the index selects and then moves the index on to the next slot. A host can therefore load a run of consecutive slots by setting the index once and streaming data words.

Any of the three data addresses feeds the same collector. The slot that a word fills depends only on how many words have arrived so far, not on the address used. A byte mask zeroes the disabled bytes of every incoming word. A commit whose index falls outside the table writes nothing. It raises a one-cycle error pulse and leaves the index where it was. The table is read through a combinational select port, and the index register can be read back at any time.

Top module: `default_vec_loader`

## Requirements
- R1: After reset, every table entry reads as zero, the index reads as zero, the word counter is at zero and the error output is low.
- R2: A write to word address 0x232 loads the index register. A write to word address 0x233, 0x234 or 0x235 is a data word. A write to any other address changes neither the index, nor the word counter, nor the table.
- R3: The byte mask is applied to each written word before it is used: byte k (bits 8k+7:8k) passes when mask bit k is 1 and becomes zero when it is 0. This applies to data words and to index writes alike.
- R4: Data words fill gather slots 0, 1 and 2 in arrival order, whichever of the three data addresses is used. The third word completes the vector and returns the counter to zero.
- R5: Table entries are read as `rd_vec` = {w, z, y, x}, with x in bits 23:0, y in 47:24, z in 71:48 and w in 95:72. The components come from the three words as follows: w = word0[31:8], z = {word0[7:0], word1[31:16]}, y = {word1[15:0], word2[31:24]}, x = word2[23:0].
- R6: A completed vector with index below 16 is written to that entry, and the index increases by one on the same clock edge.
- R7: A completed vector with index 16 or higher writes no entry and leaves the index unchanged. `err_pulse` goes high for exactly the one cycle that follows the third word's edge.
- R8: A write to the index register returns the word counter to zero, so a partly gathered vector is discarded.
- R9: `rd_vec` follows `rd_sel` combinationally. An entry that is being written still shows its old value in the cycle of the third word and shows the new value from the next cycle on.
- R10: `idx_out` always shows the current index register value, 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte mask, one bit per byte |
| rd_sel | input | 4 | Table entry to read |
| rd_vec | output | 96 | Selected entry as {w, z, y, x} |
| idx_out | output | 8 | Current index register value |
| err_pulse | output | 1 | One-cycle out-of-range commit flag |

## Verification
Two functions can fall in the same cycle: a vector commit into an entry and a combinational read of that same entry. The bench holds `rd_sel` on the entry being filled while the third word is driven. It judges the read twice, once before the edge against the old contents and once after the edge against the new vector. A second overlap is the index increment against the bounds test on the following vector. It is provoked by committing at index 15 and then at 16, and it is judged by the index value, the unchanged table and the single error pulse.

// File: rtl/dva_pkg.sv
package dva_pkg;
  localparam int COMP_W  = 24;
  localparam int WORD_W  = 32;
  localparam int BYTES   = WORD_W / 8;
  localparam int VEC_W   = 4 * COMP_W;

  typedef logic [COMP_W-1:0] comp_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    comp_t w;
    comp_t z;
    comp_t y;
    comp_t x;
  } vec_t;

  // zero every byte whose enable is low
  function automatic word_t apply_mask(input word_t d, input logic [BYTES-1:0] be);
    word_t r;
    for (int b = 0; b < BYTES; b++) begin
      r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
    end
    return r;
  endfunction

  // split three gathered words into four components, w first
  function automatic vec_t unpack_words(input word_t w0, input word_t w1, input word_t w2);
    vec_t v;
    v.w = w0[31:8];
    v.z = {w0[7:0], w1[31:16]};
    v.y = {w1[15:0], w2[31:24]};
    v.x = w2[23:0];
    return v;
  endfunction
endpackage

// File: rtl/dva_word_gather.sv
module dva_word_gather
  import dva_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_we,
  input  logic  restart,
  input  word_t word_in,
  output logic  vec_done,
  output word_t held0,
  output word_t held1,
  output logic [1:0] cnt
);
  localparam int HELD = 2;

  word_t held_q [HELD];
  logic [1:0] cnt_q;

  assign vec_done = data_we && (cnt_q == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (data_we) begin
      cnt_q <= (cnt_q == 2'd2) ? 2'd0 : cnt_q + 2'd1;
    end
  end

  for (genvar s = 0; s < HELD; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q[s] <= '0;
      end else if (data_we && !restart && cnt_q == 2'(s)) begin
        held_q[s] <= word_in;
      end
    end
  end

  assign held0 = held_q[0];
  assign held1 = held_q[1];
  assign cnt   = cnt_q;
endmodule

// File: rtl/dva_index_ctrl.sv
module dva_index_ctrl #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             commit_req,
  output logic [IDX_W-1:0] idx,
  output logic             commit_ok,
  output logic             commit_bad,
  output logic             err
);
  logic [IDX_W-1:0] idx_q;
  logic             err_q;
  logic             in_range;

  assign in_range   = idx_q < IDX_W'(ENTRIES);
  assign commit_ok  = commit_req && in_range;
  assign commit_bad = commit_req && !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= commit_bad;
      if (idx_we) begin
        idx_q <= idx_wdata;
      end else if (commit_ok) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign idx = idx_q;
  assign err = err_q;
endmodule

// File: rtl/dva_vec_table.sv
module dva_vec_table
  import dva_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int SEL_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] waddr,
  input  vec_t             wvec,
  input  logic [SEL_W-1:0] rsel,
  output vec_t             rvec
);
  vec_t ent_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (we && waddr == SEL_W'(e)) begin
        ent_q[e] <= wvec;
      end
    end
  end

  assign rvec = ent_q[rsel];
endmodule

// File: rtl/default_vec_loader.sv
module default_vec_loader
  import dva_pkg::*;
#(
  parameter int              ENTRIES   = 16,
  parameter int              IDX_W     = 8,
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h232
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [3:0]                 wr_be,
  input  logic [$clog2(ENTRIES)-1:0] rd_sel,
  output logic [VEC_W-1:0]           rd_vec,
  output logic [IDX_W-1:0]           idx_out,
  output logic                       err_pulse
);
  localparam int SEL_W = $clog2(ENTRIES);
  localparam logic [ADDR_W-1:0] DATA_LO = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DATA_HI = BASE_ADDR + ADDR_W'(3);

  // named internal events, also seen by the checker
  word_t            masked_word;
  logic             idx_load;
  logic             data_load;
  logic             vec_done;
  logic             commit_ok;
  logic             commit_bad;
  logic [1:0]       gather_cnt;
  logic [IDX_W-1:0] idx;
  word_t            held0;
  word_t            held1;
  vec_t             new_vec;
  vec_t             rd_struct;

  assign masked_word = apply_mask(wr_data, wr_be);
  assign idx_load    = wr_en && (wr_addr == BASE_ADDR);
  assign data_load   = wr_en && (wr_addr >= DATA_LO) && (wr_addr <= DATA_HI);

  dva_word_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_we  (data_load),
    .restart  (idx_load),
    .word_in  (masked_word),
    .vec_done (vec_done),
    .held0    (held0),
    .held1    (held1),
    .cnt      (gather_cnt)
  );

  dva_index_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (idx_load),
    .idx_wdata  (masked_word[IDX_W-1:0]),
    .commit_req (vec_done),
    .idx        (idx),
    .commit_ok  (commit_ok),
    .commit_bad (commit_bad),
    .err        (err_pulse)
  );

  assign new_vec = unpack_words(held0, held1, masked_word);

  dva_vec_table #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_ok),
    .waddr (idx[SEL_W-1:0]),
    .wvec  (new_vec),
    .rsel  (rd_sel),
    .rvec  (rd_struct)
  );

  assign rd_vec  = rd_struct;
  assign idx_out = idx;
endmodule

// File: rtl/dva_checker.sv
module dva_checker #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_load,
  input logic             data_load,
  input logic             commit_ok,
  input logic             commit_bad,
  input logic [1:0]       gather_cnt,
  input logic [IDX_W-1:0] idx,
  input logic             err_pulse
);
  // R4: counter never leaves slots 0..2
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gather_cnt <= 2'd2);

  // R4: third data word returns counter to zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_load && gather_cnt == 2'd2 && !idx_load) |=> gather_cnt == 2'd0);

  // R6: successful commit moves index by one
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> idx == $past(idx) + 1'b1);

  // R6: only in-range commits write
  p_ok_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |-> idx < IDX_W'(ENTRIES));

  // R7: bad commit keeps index and raises error next cycle
  p_bad_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad |=> ($stable(idx) && err_pulse));

  // R7: error lasts one cycle
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R8: index write restarts gathering
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> gather_cnt == 2'd0);
endmodule

bind default_vec_loader dva_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idx_load   (idx_load),
  .data_load  (data_load),
  .commit_ok  (commit_ok),
  .commit_bad (commit_bad),
  .gather_cnt (gather_cnt),
  .idx        (idx),
  .err_pulse  (err_pulse)
);

// File: tb/default_vec_loader_tb.sv
`timescale 1ns/1ps
module default_vec_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [3:0]  rd_sel = '0;
  logic [95:0] rd_vec;
  logic [7:0]  idx_out;
  logic        err_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // behavioural reference model
  logic [95:0] m_tab [16];
  int          m_idx;
  logic [31:0] m_words [$];
  bit          m_err;

  default_vec_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_sel(rd_sel),
    .rd_vec(rd_vec), .idx_out(idx_out), .err_pulse(err_pulse)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string what, input logic [95:0] act, input logic [95:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_word(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return d & m;
  endfunction

  task automatic model_write(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] v = mask_word(d, be);
    if (a == 10'h232) begin
      m_idx = int'(v[7:0]);
      m_words.delete();
    end else if (a >= 10'h233 && a <= 10'h235) begin
      m_words.push_back(v);
      if (m_words.size() == 3) begin
        if (m_idx < 16) begin
          m_tab[m_idx] = {m_words[0], m_words[1], m_words[2]};
          m_idx++;
        end else begin
          m_err = 1'b1;
        end
        m_words.delete();
      end
    end
  endtask

  // one clock: drive at negedge, judge the read before the edge, then all outputs after it
  task automatic step(input bit en, input logic [9:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [3:0] sel, input string tag);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d; wr_be = be; rd_sel = sel;
    #1;
    check(rd_vec === m_tab[sel], {tag, " R9 pre-edge read"}, rd_vec, m_tab[sel]);
    @(posedge clk);
    #1;
    m_err = 1'b0;
    if (en) model_write(a, d, be);
    check(idx_out === 8'(m_idx), {tag, " R10 index"}, 96'(idx_out), 96'(m_idx));
    check(err_pulse === m_err, {tag, " R7 error pulse"}, 96'(err_pulse), 96'(m_err));
    check(rd_vec === m_tab[sel], {tag, " R9 post-edge read"}, rd_vec, m_tab[sel]);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] sel, input string tag);
    step(1'b1, a, d, 4'hF, sel, tag);
  endtask

  task automatic idle(input logic [3:0] sel, input string tag);
    step(1'b0, 10'h000, 32'h0, 4'h0, sel, tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        n_tests++;
        $display("FAIL watchdog act=%0d exp=<20000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : stim
    for (int i = 0; i < 16; i++) m_tab[i] = '0;
    m_idx = 0;
    m_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 16; i++) idle(4'(i), "R1 reset");

    // R10, R2: index load and readback
    wr(10'h232, 32'h0000_0005, 4'd5, "R10 idx load");
    // R5, R6: three distinct data addresses
    wr(10'h233, 32'hA1B2_C3D4, 4'd5, "R5 w0");
    wr(10'h234, 32'hE5F6_0718, 4'd5, "R5 w1");
    wr(10'h235, 32'h293A_4B5C, 4'd5, "R9 R6 commit same-cycle read");
    check(rd_vec[95:72] === 24'hA1B2C3, "R5 w field", 96'(rd_vec[95:72]), 96'h0A1B2C3);
    check(rd_vec[71:48] === 24'hD4E5F6, "R5 z field", 96'(rd_vec[71:48]), 96'h0D4E5F6);
    check(rd_vec[47:24] === 24'h071829, "R5 y field", 96'(rd_vec[47:24]), 96'h0071829);
    check(rd_vec[23:0]  === 24'h3A4B5C, "R5 x field", 96'(rd_vec[23:0]),  96'h03A4B5C);
    check(idx_out === 8'd6, "R6 index advanced", 96'(idx_out), 96'd6);

    // R4: one address used three times
    for (int k = 0; k < 3; k++) wr(10'h235, 32'h1111_0000 + k, 4'd6, "R4 same address");
    // R4: reverse address order
    wr(10'h235, 32'h0102_0304, 4'd7, "R4 reverse");
    wr(10'h234, 32'h0506_0708, 4'd7, "R4 reverse");
    wr(10'h233, 32'h090A_0B0C, 4'd7, "R4 reverse");

    // R3: byte mask on data and on index
    step(1'b1, 10'h233, 32'hFFFF_FFFF, 4'b0101, 4'd8, "R3 mask");
    step(1'b1, 10'h234, 32'hFFFF_FFFF, 4'b1010, 4'd8, "R3 mask");
    step(1'b1, 10'h235, 32'hFFFF_FFFF, 4'b0000, 4'd8, "R3 mask");
    step(1'b1, 10'h232, 32'h0000_0009, 4'b1110, 4'd0, "R3 idx mask");
    check(idx_out === 8'd0, "R3 masked index", 96'(idx_out), 96'd0);

    // R2: foreign addresses between words have no effect
    wr(10'h233, 32'hCAFE_0001, 4'd0, "R2 w0");
    wr(10'h236, 32'hDEAD_BEEF, 4'd0, "R2 foreign hi");
    wr(10'h231, 32'h0000_000C, 4'd0, "R2 foreign lo");
    wr(10'h234, 32'hCAFE_0002, 4'd0, "R2 w1");
    wr(10'h235, 32'hCAFE_0003, 4'd0, "R2 commit");

    // R8: index write discards partial vector
    wr(10'h233, 32'hBAD0_0001, 4'd3, "R8 partial");
    wr(10'h234, 32'hBAD0_0002, 4'd3, "R8 partial");
    wr(10'h232, 32'h0000_0003, 4'd3, "R8 restart");
    wr(10'h233, 32'h3333_0001, 4'd3, "R8 fresh");
    wr(10'h234, 32'h3333_0002, 4'd3, "R8 fresh");
    wr(10'h235, 32'h3333_0003, 4'd3, "R8 fresh");

    // R6, R7: commit at 15 then out-of-range at 16
    wr(10'h232, 32'h0000_000F, 4'd15, "R6 idx 15");
    for (int k = 0; k < 3; k++) wr(10'h233 + 10'(k), 32'h0F0F_0000 + k, 4'd15, "R6 last entry");
    check(idx_out === 8'd16, "R6 index reaches 16", 96'(idx_out), 96'd16);
    for (int k = 0; k < 3; k++) wr(10'h234, 32'h7777_0000 + k, 4'd0, "R7 out of range");
    idle(4'd0, "R7 pulse gone");
    wr(10'h232, 32'h0000_00C8, 4'd15, "R7 idx 200");
    for (int k = 0; k < 3; k++) wr(10'h235, 32'h8888_0000 + k, 4'd15, "R7 far index");
    idle(4'd15, "R7 idle");

    // R6: run of consecutive slots from zero
    wr(10'h232, 32'h0000_0000, 4'd0, "R6 run start");
    for (int e = 0; e < 16; e++)
      for (int k = 0; k < 3; k++)
        wr(10'h233 + 10'(k), {8'(e), 8'(k), 16'hA55A ^ 16'(e * 7)}, 4'(e), "R6 run");
    for (int i = 0; i < 16; i++) idle(4'(i), "R6 run readback");

    @(negedge clk);
    wr_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule